// File: doc/BRIEF.md
# Dual-Mode Processor Bus Register Bridge

This block connects an external 8-bit processor bus to the internal register file of a sixteen-channel line-interface device. A strap input picks one of two bus styles. In the first style, the address bus and the data lines are separate, and a data strobe is qualified by a read/write level. In the second style, the data lines first carry the low address byte and then the data, and separate read and write strobes are used. The block latches the register address when the address strobe falls. Two active-low chip selects each cover half of the channels. The block issues single-cycle internal read and write pulses, and it drives read data back with its own output enable.

A second strap sets the timing mode. In synchronous mode, the block clock is the processor clock, and bus inputs are registered through one stage. In asynchronous mode, the block clock is an internal free-running clock, and every bus input passes through a multi-flop synchronizer before edge detection. The address and data lines are delayed by the same number of stages as the strobes, so that they stay aligned with the strobes. The reset input is asynchronous and active low. It must be held for at least two clocks. While reset is low, every output returns to idle and the data lines are released.

Top module: `cpu_bus_bridge`

## Requirements
- R1: While `rstN` is low and after it is released, `regWr`, `regRd`, `adOe` and `dualSelErr` are 0 and `regAddr` is 0.
- R2: With `intelMode`=0, a falling edge on `asN` latches all 12 bits of `addrIn` into `regAddr[11:0]`, and `adIn` is ignored during address latching.
- R3: With `intelMode`=1, a falling edge on `asN` latches `{addrIn[11:8], adIn[7:0]}` into `regAddr[11:0]`, and `addrIn[7:0]` has no effect.
- R4: With `intelMode`=0, `dsN` low with `rwN` low is a write cycle, and `dsN` low with `rwN` high is a read cycle.
- R5: With `intelMode`=1, `dsN` low is a read strobe and `rwN` low is a write strobe. Both strobes low at once is treated as no access.
- R6: Each write cycle produces exactly one single-cycle `regWr` pulse when the write strobe is released. `regWdata` holds the `adIn` value sampled while the strobe was still active, so a change of `adIn` at the moment of release is not captured.
- R7: Each read cycle produces exactly one single-cycle `regRd` pulse at the start of the strobe. `adOe` then drives `adOut` with the returned `regRdata` until the read strobe or the chip select is released.
- R8: `regAddr[12]` is 0 for an access made with `csLoN` and 1 for an access made with `csHiN`.
- R9: When `csLoN` and `csHiN` are both low, strobes produce no `regWr`, no `regRd` and no `adOe`, and `dualSelErr` is set. `dualSelErr` stays 1 until reset.
- R10: Counting from the first rising clock edge after the write strobe is released, `regWr` is 1 after edge N+1 and 0 after edge N. N is 1 with `syncMode`=1 and SYNC_STAGES with `syncMode`=0.
- R11: Strobes applied while both chip selects are high produce no `regWr` or `regRd` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock: processor clock in synchronous mode, internal clock otherwise |
| rstN | input | 1 | Asynchronous active-low reset |
| syncMode | input | 1 | Timing strap: 1 synchronous, 0 asynchronous |
| intelMode | input | 1 | Bus-style strap: 1 multiplexed with read/write strobes, 0 separate with data strobe |
| asN | input | 1 | Address strobe, active low, latches on falling edge |
| csLoN | input | 1 | Chip select for channels 1 to 8, active low |
| csHiN | input | 1 | Chip select for channels 9 to 16, active low |
| dsN | input | 1 | Data strobe (separate bus) or read strobe (multiplexed bus) |
| rwN | input | 1 | Read/write level (separate bus) or write strobe (multiplexed bus) |
| addrIn | input | 12 | Address lines |
| adIn | input | 8 | Data lines, inbound |
| adOut | output | 8 | Data lines, outbound read data |
| adOe | output | 1 | Output enable for the data lines |
| regAddr | output | 13 | Register select: channel-group bit above the 12-bit latched address |
| regWr | output | 1 | Internal write pulse |
| regRd | output | 1 | Internal read pulse |
| regWdata | output | 8 | Internal write data |
| regRdata | input | 8 | Data returned by the register file in the `regRd` cycle |
| dualSelErr | output | 1 | Sticky flag: both chip selects were seen low together |

## Verification
A sweep crosses both bus styles, both timing modes and both chip selects with several addresses. In each address, the bits that must be ignored carry the inverted value, so a latch that takes the wrong source shows up as a wrong `regAddr`. Reads release the chip select first in one case and the strobe first in the others, which shows whether both releases end the drive on the data lines. Writes change the data lines at the moment of release, which shows whether the data is sampled before or after the trailing edge. Separate cases apply strobes with no chip select and with both chip selects low, and they measure the exact write latency in each timing mode.

// File: rtl/cpu_bus_bridge_pkg.sv
package cpu_bus_bridge_pkg;

  // Control-to-datapath strobes, one set per clock
  typedef struct packed {
    logic addrLatch;  // address strobe fell
    logic wrPulse;    // qualified write strobe released
    logic rdPulse;    // qualified read strobe started
    logic rdActive;   // qualified read strobe currently held
    logic conflict;   // both chip selects low
    logic group;      // channel group of the current pulse
  } ctlStrobes_t;

endpackage

// File: rtl/cpu_bus_bridge_sync.sv
module cpu_bus_bridge_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] firstOut,
  output logic [WIDTH-1:0] lastOut
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    if (STAGES < 2) begin : g_badDepth
      $error("STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], dIn};
  end

  assign firstOut = pipe[0];
  assign lastOut  = pipe[STAGES-1];

endmodule

// File: rtl/cpu_bus_bridge_ctrl.sv
module cpu_bus_bridge_ctrl
  import cpu_bus_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncMode,
  input  logic        intelMode,
  input  logic        asN,
  input  logic        csLoN,
  input  logic        csHiN,
  input  logic        dsN,
  input  logic        rwN,
  output ctlStrobes_t strobes
);

  localparam int CTL_W = 5;

  logic [CTL_W-1:0] rawIn, firstIn, lastIn, selIn;
  logic asCur, csLo, csHi, dsLow, rwLow;
  logic csOne, rdStb, wrStb, rdQual, wrQual;
  logic asPrev, rdQualPrev, wrQualPrev, groupPrev;

  assign rawIn = {asN, csHiN, csLoN, dsN, rwN};

  cpu_bus_bridge_sync #(
    .WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RESET_VAL({CTL_W{1'b1}})
  ) u_ctlSync (
    .clk(clk), .rstN(rstN), .dIn(rawIn), .firstOut(firstIn), .lastOut(lastIn)
  );

  assign selIn = syncMode ? firstIn : lastIn;
  assign asCur = selIn[4];
  assign csHi  = ~selIn[3];
  assign csLo  = ~selIn[2];
  assign dsLow = ~selIn[1];
  assign rwLow = ~selIn[0];

  assign csOne = csLo ^ csHi;

  always_comb begin
    if (intelMode) begin
      rdStb = dsLow & ~rwLow;
      wrStb = rwLow & ~dsLow;
    end else begin
      rdStb = dsLow & ~rwLow;
      wrStb = dsLow & rwLow;
    end
  end

  assign rdQual = rdStb & csOne;
  assign wrQual = wrStb & csOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asPrev     <= 1'b1;
      rdQualPrev <= 1'b0;
      wrQualPrev <= 1'b0;
      groupPrev  <= 1'b0;
    end else begin
      asPrev     <= asCur;
      rdQualPrev <= rdQual;
      wrQualPrev <= wrQual;
      groupPrev  <= csHi;
    end
  end

  always_comb begin
    strobes.addrLatch = asPrev & ~asCur;
    strobes.wrPulse   = wrQualPrev & ~wrQual;
    strobes.rdPulse   = rdQual & ~rdQualPrev;
    strobes.rdActive  = rdQual;
    strobes.conflict  = csLo & csHi;
    strobes.group     = strobes.wrPulse ? groupPrev : csHi;
  end

  AST_ADDR_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.addrLatch |=> !strobes.addrLatch); // R2

  AST_RD_NEEDS_ONE_CS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdPulse |-> !strobes.conflict); // R9

endmodule

// File: rtl/cpu_bus_bridge_dp.sv
module cpu_bus_bridge_dp
  import cpu_bus_bridge_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncMode,
  input  logic              intelMode,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] adIn,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W:0]   regAddr,
  output logic              regWr,
  output logic              regRd,
  output logic [DATA_W-1:0] regWdata,
  output logic              dualSelErr
);

  localparam int BUS_W = ADDR_W + DATA_W;
  localparam int HI_W  = ADDR_W - DATA_W;

  logic [BUS_W-1:0]  rawBus, firstBus, lastBus, selBus;
  logic [ADDR_W-1:0] selAddr, muxAddr, addrLatched;
  logic [DATA_W-1:0] selAd, adPrev, rdHold;
  logic              groupReg, holdValid;

  assign rawBus = {addrIn, adIn};

  cpu_bus_bridge_sync #(
    .WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)
  ) u_busSync (
    .clk(clk), .rstN(rstN), .dIn(rawBus), .firstOut(firstBus), .lastOut(lastBus)
  );

  assign selBus  = syncMode ? firstBus : lastBus;
  assign selAddr = selBus[BUS_W-1:DATA_W];
  assign selAd   = selBus[DATA_W-1:0];

  generate
    if (HI_W > 0) begin : g_muxAddr
      assign muxAddr = intelMode ? {selAddr[ADDR_W-1:DATA_W], selAd} : selAddr;
    end else begin : g_narrowAddr
      assign muxAddr = intelMode ? selAd[ADDR_W-1:0] : selAddr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adPrev      <= '0;
      addrLatched <= '0;
      groupReg    <= 1'b0;
      regWr       <= 1'b0;
      regRd       <= 1'b0;
      regWdata    <= '0;
      rdHold      <= '0;
      holdValid   <= 1'b0;
      dualSelErr  <= 1'b0;
    end else begin
      adPrev <= selAd;
      regWr  <= strobes.wrPulse;
      regRd  <= strobes.rdPulse;
      if (strobes.addrLatch) addrLatched <= muxAddr;
      if (strobes.wrPulse || strobes.rdPulse) groupReg <= strobes.group;
      if (strobes.wrPulse) regWdata <= adPrev;
      if (!strobes.rdActive) begin
        holdValid <= 1'b0;
      end else if (regRd) begin
        rdHold    <= regRdata;
        holdValid <= 1'b1;
      end
      if (strobes.conflict) dualSelErr <= 1'b1;
    end
  end

  assign regAddr = {groupReg, addrLatched};
  assign adOut   = rdHold;
  assign adOe    = holdValid & strobes.rdActive;

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> !regWr); // R6

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> !regRd); // R7

  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adOe) |-> $past(regRd)); // R7

  AST_NO_OE_CONFLICT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.conflict |-> !adOe); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    dualSelErr |=> dualSelErr); // R9

endmodule

// File: rtl/cpu_bus_bridge.sv
module cpu_bus_bridge
  import cpu_bus_bridge_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncMode,
  input  logic              intelMode,
  input  logic              asN,
  input  logic              csLoN,
  input  logic              csHiN,
  input  logic              dsN,
  input  logic              rwN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W:0]   regAddr,
  output logic              regWr,
  output logic              regRd,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic              dualSelErr
);

  ctlStrobes_t strobes;

  cpu_bus_bridge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .intelMode(intelMode),
    .asN(asN), .csLoN(csLoN), .csHiN(csHiN), .dsN(dsN), .rwN(rwN),
    .strobes(strobes)
  );

  cpu_bus_bridge_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .intelMode(intelMode),
    .strobes(strobes), .addrIn(addrIn), .adIn(adIn), .regRdata(regRdata),
    .adOut(adOut), .adOe(adOe), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .regWdata(regWdata), .dualSelErr(dualSelErr)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |-> (!regWr && !regRd && !adOe)); // R1

endmodule

// File: tb/cpu_bus_bridge_bench.sv
`timescale 1ns/1ps
module cpu_bus_bridge_bench;

  localparam int SYNC_STAGES = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncMode = 1'b0, intelMode = 1'b0;
  logic        asN = 1'b1, csLoN = 1'b1, csHiN = 1'b1, dsN = 1'b1, rwN = 1'b1;
  logic [11:0] addrIn = '0;
  logic [7:0]  adIn = '0;
  logic [7:0]  adOut, regWdata, regRdata;
  logic        adOe, regWr, regRd, dualSelErr;
  logic [12:0] regAddr;

  int checks = 0, errors = 0;
  int wrCount = 0, rdCount = 0;
  logic [12:0] lastWrAddr = '0, lastRdAddr = '0;
  logic [7:0]  lastWrData = '0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] regModel(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  assign regRdata = regModel(regAddr);

  cpu_bus_bridge #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_bus_bridge (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .intelMode(intelMode),
    .asN(asN), .csLoN(csLoN), .csHiN(csHiN), .dsN(dsN), .rwN(rwN),
    .addrIn(addrIn), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .dualSelErr(dualSelErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (regWr) begin
        wrCount++;
        lastWrAddr = regAddr;
        lastWrData = regWdata;
      end
      if (regRd) begin
        rdCount++;
        lastRdAddr = regAddr;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    repeat (6) @(negedge clk);
  endtask

  task automatic addrPhase(input bit intel, input logic [11:0] addr);
    if (intel) begin
      addrIn = {addr[11:8], ~addr[7:0]};
      adIn   = addr[7:0];
    end else begin
      addrIn = addr;
      adIn   = ~addr[7:0];
    end
    step(); asN = 1'b0; step(); asN = 1'b1; step();
  endtask

  task automatic doWrite(input bit intel, input bit grp,
                         input logic [11:0] addr, input logic [7:0] data);
    int w0;
    w0 = wrCount;
    addrPhase(intel, addr);
    adIn = data;
    if (grp) csHiN = 1'b0; else csLoN = 1'b0;
    if (intel) begin
      rwN = 1'b0; step(); rwN = 1'b1; adIn = ~data;
    end else begin
      rwN = 1'b0; step(); dsN = 1'b0; step(); dsN = 1'b1; adIn = ~data;
    end
    step();
    rwN = 1'b1; csLoN = 1'b1; csHiN = 1'b1;
    step();
    check(wrCount == w0 + 1, intel ? "R5" : "R4", "write pulse count", wrCount - w0, 1);
    check(lastWrAddr == {grp, addr}, intel ? "R3" : "R2", "write address", lastWrAddr, {grp, addr});
    check(lastWrAddr[12] == grp, "R8", "group bit", lastWrAddr[12], grp);
    check(lastWrData == data, "R6", "write data", lastWrData, data);
  endtask

  task automatic doRead(input bit intel, input bit grp, input logic [11:0] addr,
                        input bit csFirst);
    int r0;
    logic [7:0] expData;
    r0 = rdCount;
    expData = regModel({grp, addr});
    addrPhase(intel, addr);
    if (grp) csHiN = 1'b0; else csLoN = 1'b0;
    rwN = 1'b1;
    step();
    dsN = 1'b0;
    step();
    check(adOe == 1'b1, "R7", "output enable during read", adOe, 1);
    check(adOut == expData, "R7", "read data", adOut, expData);
    if (csFirst) begin csLoN = 1'b1; csHiN = 1'b1; end
    else dsN = 1'b1;
    step();
    check(adOe == 1'b0, "R7", "output enable after release", adOe, 0);
    dsN = 1'b1; csLoN = 1'b1; csHiN = 1'b1;
    step();
    check(rdCount == r0 + 1, intel ? "R5" : "R4", "read pulse count", rdCount - r0, 1);
    check(lastRdAddr == {grp, addr}, "R8", "read address", lastRdAddr, {grp, addr});
  endtask

  task automatic latency(input bit sMode);
    int n;
    n = sMode ? 1 : SYNC_STAGES;
    syncMode = sMode; intelMode = 1'b0;
    step();
    csLoN = 1'b0; rwN = 1'b0; adIn = 8'h3C; step();
    dsN = 1'b0; step();
    dsN = 1'b1;
    repeat (n) @(posedge clk);
    #1 check(regWr == 1'b0, "R10", "write pulse too early", regWr, 0);
    @(posedge clk);
    #1 check(regWr == 1'b1, "R10", "write pulse at expected edge", regWr, 1);
    @(negedge clk);
    rwN = 1'b1; csLoN = 1'b1;
    step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int w0, r0;
    repeat (4) @(negedge clk);
    check(regWr == 0 && regRd == 0, "R1", "pulses in reset", {regWr, regRd}, 0);
    check(adOe == 0, "R1", "oe in reset", adOe, 0);
    check(dualSelErr == 0, "R1", "error in reset", dualSelErr, 0);
    rstN = 1'b1;
    step();
    check(regAddr == 0, "R1", "address after reset", regAddr, 0);

    // sweep: mode bit0 = bus style, bit1 = timing
    for (int m = 0; m < 4; m++) begin
      intelMode = m[0];
      syncMode  = m[1];
      for (int g = 0; g < 2; g++) begin
        for (int i = 0; i < 3; i++) begin
          logic [11:0] a;
          logic [7:0]  d;
          a = 12'((m * 613 + g * 97 + i * 1111 + 5) & 12'hFFF);
          d = 8'((a * 7 + i) & 8'hFF);
          doWrite(m[0], g[0], a, d);
          doRead(m[0], g[0], 12'(a ^ 12'h5A5), i == 0);
        end
      end
    end

    // R11: strobes without chip select
    intelMode = 1'b0; syncMode = 1'b0;
    w0 = wrCount; r0 = rdCount;
    rwN = 1'b0; step(); dsN = 1'b0; step(); dsN = 1'b1; step();
    rwN = 1'b1; step(); dsN = 1'b0; step();
    check(adOe == 0, "R11", "oe without chip select", adOe, 0);
    dsN = 1'b1; step();
    check(wrCount == w0, "R11", "write without chip select", wrCount - w0, 0);
    check(rdCount == r0, "R11", "read without chip select", rdCount - r0, 0);

    // R9: both chip selects low
    addrPhase(1'b0, 12'h123);
    csLoN = 1'b0; csHiN = 1'b0;
    rwN = 1'b0; step(); dsN = 1'b0; step(); dsN = 1'b1; step();
    rwN = 1'b1; step(); dsN = 1'b0; step();
    check(adOe == 0, "R9", "oe under dual select", adOe, 0);
    dsN = 1'b1; csLoN = 1'b1; csHiN = 1'b1; step();
    check(wrCount == w0, "R9", "write under dual select", wrCount - w0, 0);
    check(rdCount == r0, "R9", "read under dual select", rdCount - r0, 0);
    check(dualSelErr == 1, "R9", "error flag set", dualSelErr, 1);
    doWrite(1'b0, 1'b1, 12'hABC, 8'h77);
    check(dualSelErr == 1, "R9", "error flag sticky", dualSelErr, 1);
    rstN = 1'b0; step();
    check(dualSelErr == 0, "R1", "error cleared by reset", dualSelErr, 0);
    rstN = 1'b1; step();

    // R10: write latency in both timing modes
    latency(1'b1);
    latency(1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule